// File: doc/BRIEF.md
# Debug Status and Control Register

This block holds the control and status bits that an external debugger uses to steer a processor core during debug. Four writable control bits arm instruction injection from the instruction transfer register, mask the core's IRQ and FIQ lines, force the debug-acknowledge output high, and forbid user-mode software from touching the debug registers. Three sticky flags record an undefined-instruction exception, an imprecise data abort and a precise data abort, but only when they happen while the core is in debug state.

The sticky flags cannot be cleared through the register's own write port. They are cleared only by a command bit written to a separate run-control port. If a clear command and an event for the same flag arrive in one cycle, the event wins.

Both the register port and the run-control port are plain write strobes with no back-pressure. A write is accepted in the cycle its strobe is high and takes effect at the next clock edge. Reads are combinational and always return the current state. The interrupt, trap, fetch and status pins are plain level signals with no handshake.

Top module: `dbg_dscr`

## Requirements
- R1: While reset is active, and right after it, every control bit and every sticky flag is 0. The read data is all zeros, and dbgack equals in_debug.
- R2: A register write with reg_wr_en high loads the four control bits from reg_wdata at the next clock edge. The bits sit at these positions: 13 instruction-execute enable, 12 user-access block, 11 interrupt mask, 10 acknowledge force. reg_rdata shows them at the same positions, combinationally.
- R3: While bit 12 is 1, user_acc raises undef_trap in the same cycle. While bit 12 is 0, undef_trap stays low.
- R4: While bit 11 is 0, irq_gated and fiq_gated follow irq_raw and fiq_raw. While bit 11 is 1, both gated outputs are low.
- R5: dbgack is high whenever in_debug is high or bit 10 is 1.
- R6: Bit 9 and every bit outside 13..6 read as 0, whatever value was written to them.
- R7: An event seen while in_debug is high sets its flag at the next edge: ev_undef sets bit 8, ev_imp_abort sets bit 7 and ev_prec_abort sets bit 6. Events seen while in_debug is low change nothing.
- R8: A set flag stays set until a run-control write has rc_wdata bit 2 at 1. Register writes, and run-control writes with bit 2 at 0, leave the flags unchanged.
- R9: If an event for a flag arrives in the same cycle as a clear command, that flag is set after the edge.
- R10: fetch_req is high in a cycle where itr_wr_ok is high, bit 13 is 1 and in_debug is high.
- R11: While bit 13 is 1 and in_debug is low, proto_err is high and fetch_req is held low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| reg_wr_en | input | 1 | Register write strobe |
| reg_wdata | input | DATA_W | Register write data |
| reg_rdata | output | DATA_W | Current register value |
| rc_wr_en | input | 1 | Run-control write strobe |
| rc_wdata | input | DATA_W | Run-control command word (bit 2 = clear flags) |
| in_debug | input | 1 | Core is in debug state |
| ev_undef | input | 1 | Undefined-instruction exception event |
| ev_imp_abort | input | 1 | Imprecise data abort event |
| ev_prec_abort | input | 1 | Precise data abort event |
| user_acc | input | 1 | User-mode access to debug registers |
| itr_wr_ok | input | 1 | Successful instruction transfer write |
| irq_raw | input | 1 | IRQ from the system |
| fiq_raw | input | 1 | FIQ from the system |
| irq_gated | output | 1 | IRQ to the core |
| fiq_gated | output | 1 | FIQ to the core |
| dbgack | output | 1 | Debug acknowledge |
| undef_trap | output | 1 | Undefined-instruction trap request |
| fetch_req | output | 1 | Instruction fetch request from the transfer register |
| proto_err | output | 1 | Execute enabled outside debug state |

## Verification
A wrong control bit becomes visible in the cycle after the write: it shows in reg_rdata and in whichever pin that bit gates, such as irq_gated, dbgack, undef_trap or fetch_req. A sticky flag that sets on its own, fails to set, or clears at the wrong time shows in reg_rdata one edge after the event or the command that went wrong. The reference model is compared against every output on every cycle, so a divergence is reported within one clock. Directed phases cover events outside debug state, writes that try to clear the flags, clear commands with bit 2 at 0, and a clear arriving together with an event.

// File: rtl/dbg_dscr_pkg.sv
package dbg_dscr_pkg;
  // Bit positions in the status/control word; a software driver decodes these.
  localparam int BIT_EXEC   = 13;
  localparam int BIT_UBLK   = 12;
  localparam int BIT_INTDIS = 11;
  localparam int BIT_ACK    = 10;
  localparam int BIT_RSVD   = 9;
  // Sticky flags occupy a contiguous field: precise, imprecise, undefined.
  localparam int N_STICKY   = 3;
  localparam int STICKY_LSB = 6;
  localparam int FLG_PRE    = 0;
  localparam int FLG_IMP    = 1;
  localparam int FLG_UND    = 2;
  // Clear-command bit in the run-control word.
  localparam int RC_CLR_BIT = 2;
  // Interrupt lines gated by the mask bit.
  localparam int N_INT_LINES = 2;

  typedef struct packed {
    logic exec_en;
    logic user_blk;
    logic int_mask;
    logic ack_force;
  } ctl_t;
endpackage

// File: rtl/dbg_ctrl_reg.sv
module dbg_ctrl_reg
  import dbg_dscr_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic wr_en,
  input  ctl_t wr_val,
  output ctl_t ctl
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     ctl <= '0;
    else if (wr_en) ctl <= wr_val;
  end

  // R2: a write lands at the next edge, otherwise the bits hold.
  a_r2_write_lands: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> (ctl == $past(wr_val)));
  a_r2_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(ctl));
endmodule

// File: rtl/dbg_sticky_bank.sv
module dbg_sticky_bank #(
  parameter int N = 3
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_debug,
  input  logic [N-1:0] ev,
  input  logic         clr,
  output logic [N-1:0] flags
);
  for (genvar i = 0; i < N; i++) begin : g_flag
    logic hit;
    assign hit = ev[i] & in_debug;

    // Set has priority over clear so that no event is lost.
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   flags[i] <= 1'b0;
      else if (hit) flags[i] <= 1'b1;
      else if (clr) flags[i] <= 1'b0;
    end

    a_r7_set_in_debug: assert property (@(posedge clk) disable iff (!rst_n)
      (ev[i] && in_debug) |=> flags[i]);
    a_r7_no_set_outside: assert property (@(posedge clk) disable iff (!rst_n)
      (!in_debug && !flags[i]) |=> !flags[i]);
    a_r8_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (flags[i] && !clr) |=> flags[i]);
    a_r8_clear: assert property (@(posedge clk) disable iff (!rst_n)
      (clr && !(ev[i] && in_debug)) |=> !flags[i]);
    a_r9_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
      (clr && ev[i] && in_debug) |=> flags[i]);
  end
endmodule

// File: rtl/dbg_irq_gate.sv
module dbg_irq_gate #(
  parameter int N = 2
) (
  input  logic [N-1:0] raw,
  input  logic         mask,
  output logic [N-1:0] gated
);
  for (genvar i = 0; i < N; i++) begin : g_line
    assign gated[i] = raw[i] & ~mask;
  end
endmodule

// File: rtl/dbg_dscr.sv
module dbg_dscr
  import dbg_dscr_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr_en,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  input  logic              rc_wr_en,
  input  logic [DATA_W-1:0] rc_wdata,
  input  logic              in_debug,
  input  logic              ev_undef,
  input  logic              ev_imp_abort,
  input  logic              ev_prec_abort,
  input  logic              user_acc,
  input  logic              itr_wr_ok,
  input  logic              irq_raw,
  input  logic              fiq_raw,
  output logic              irq_gated,
  output logic              fiq_gated,
  output logic              dbgack,
  output logic              undef_trap,
  output logic              fetch_req,
  output logic              proto_err
);
  ctl_t                   ctl;
  ctl_t                   wr_val;
  logic [N_STICKY-1:0]    ev_vec;
  logic [N_STICKY-1:0]    flags;
  logic                   clr_cmd;
  logic [N_INT_LINES-1:0] int_raw;
  logic [N_INT_LINES-1:0] int_gated;
  logic                   unused_wbits;

  // Only the control field of a register write is kept; the rest is dropped.
  assign wr_val.exec_en   = reg_wdata[BIT_EXEC];
  assign wr_val.user_blk  = reg_wdata[BIT_UBLK];
  assign wr_val.int_mask  = reg_wdata[BIT_INTDIS];
  assign wr_val.ack_force = reg_wdata[BIT_ACK];
  assign unused_wbits     = ^{reg_wdata, rc_wdata};

  dbg_ctrl_reg u_ctrl (
    .clk    (clk),
    .rst_n  (rst_n),
    .wr_en  (reg_wr_en),
    .wr_val (wr_val),
    .ctl    (ctl)
  );

  assign ev_vec[FLG_PRE] = ev_prec_abort;
  assign ev_vec[FLG_IMP] = ev_imp_abort;
  assign ev_vec[FLG_UND] = ev_undef;
  assign clr_cmd         = rc_wr_en & rc_wdata[RC_CLR_BIT];

  dbg_sticky_bank #(.N(N_STICKY)) u_sticky (
    .clk      (clk),
    .rst_n    (rst_n),
    .in_debug (in_debug),
    .ev       (ev_vec),
    .clr      (clr_cmd),
    .flags    (flags)
  );

  assign int_raw = {fiq_raw, irq_raw};

  dbg_irq_gate #(.N(N_INT_LINES)) u_gate (
    .raw   (int_raw),
    .mask  (ctl.int_mask),
    .gated (int_gated)
  );

  assign irq_gated = int_gated[0];
  assign fiq_gated = int_gated[1];

  assign dbgack     = in_debug | ctl.ack_force;
  assign undef_trap = user_acc & ctl.user_blk;
  assign fetch_req  = itr_wr_ok & ctl.exec_en & in_debug;
  assign proto_err  = ctl.exec_en & ~in_debug;

  always_comb begin
    reg_rdata                               = '0;
    reg_rdata[BIT_EXEC]                     = ctl.exec_en;
    reg_rdata[BIT_UBLK]                     = ctl.user_blk;
    reg_rdata[BIT_INTDIS]                   = ctl.int_mask;
    reg_rdata[BIT_ACK]                      = ctl.ack_force;
    reg_rdata[STICKY_LSB +: N_STICKY]       = flags;
  end

  a_r3_trap_after_block: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr_en && reg_wdata[BIT_UBLK]) |=> (!user_acc || undef_trap));
  a_r4_masked_after_write: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr_en && reg_wdata[BIT_INTDIS]) |=> !(irq_gated || fiq_gated));
  a_r5_ack_forced: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr_en && reg_wdata[BIT_ACK]) |=> dbgack);
  a_r5_ack_in_debug: assert property (@(posedge clk) disable iff (!rst_n)
    in_debug |-> dbgack);
  a_r10_fetch_needs_debug: assert property (@(posedge clk) disable iff (!rst_n)
    fetch_req |-> (itr_wr_ok && in_debug));
  a_r11_err_after_exec: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr_en && reg_wdata[BIT_EXEC]) |=> (in_debug || (proto_err && !fetch_req)));
  a_r6_reserved_zero: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(reg_wr_en) |-> !reg_rdata[BIT_RSVD]);
endmodule

// File: tb/dbg_dscr_tb.sv
module dbg_dscr_tb;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        reg_wr_en, rc_wr_en;
  logic [31:0] reg_wdata, rc_wdata, reg_rdata;
  logic        in_debug, ev_undef, ev_imp_abort, ev_prec_abort;
  logic        user_acc, itr_wr_ok, irq_raw, fiq_raw;
  logic        irq_gated, fiq_gated, dbgack, undef_trap, fetch_req, proto_err;

  always #5 clk = ~clk;

  dbg_dscr #(.DATA_W(32)) u_dut (
    .clk(clk), .rst_n(rst_n),
    .reg_wr_en(reg_wr_en), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .rc_wr_en(rc_wr_en), .rc_wdata(rc_wdata),
    .in_debug(in_debug), .ev_undef(ev_undef), .ev_imp_abort(ev_imp_abort),
    .ev_prec_abort(ev_prec_abort), .user_acc(user_acc), .itr_wr_ok(itr_wr_ok),
    .irq_raw(irq_raw), .fiq_raw(fiq_raw), .irq_gated(irq_gated),
    .fiq_gated(fiq_gated), .dbgack(dbgack), .undef_trap(undef_trap),
    .fetch_req(fetch_req), .proto_err(proto_err)
  );

  int n_cmp = 0;
  int n_bad = 0;

  // Reference state, kept as plain integers.
  int m_exec, m_ublk, m_mask, m_ack, m_und, m_imp, m_pre;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_exec = 0; m_ublk = 0; m_mask = 0; m_ack = 0;
      m_und = 0; m_imp = 0; m_pre = 0;
    end else begin
      int clr;
      clr = (rc_wr_en && rc_wdata[2]) ? 1 : 0;
      if (in_debug && ev_undef) m_und = 1; else if (clr != 0) m_und = 0;
      if (in_debug && ev_imp_abort) m_imp = 1; else if (clr != 0) m_imp = 0;
      if (in_debug && ev_prec_abort) m_pre = 1; else if (clr != 0) m_pre = 0;
      if (reg_wr_en) begin
        m_exec = int'(reg_wdata[13]); m_ublk = int'(reg_wdata[12]);
        m_mask = int'(reg_wdata[11]); m_ack  = int'(reg_wdata[10]);
      end
    end
  end

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s actual=%h expected=%h at %0t", req, what, act, exp, $time);
    end
  endtask

  task automatic compare_all();
    logic [31:0] rsv_mask;
    rsv_mask = 32'h0000_3DC0;
    // R2: control field
    chk("R2", "ctl bits", {28'd0, reg_rdata[13:10]},
        32'(m_exec*8 + m_ublk*4 + m_mask*2 + m_ack));
    // R6: reserved bit 9 and all bits outside 13..6
    chk("R6", "reserved bits", reg_rdata & ~rsv_mask, 32'd0);
    // R7 R8 R9: sticky field
    chk("R7/R8/R9", "sticky bits", {29'd0, reg_rdata[8:6]},
        32'(m_und*4 + m_imp*2 + m_pre));
    // R5
    chk("R5", "dbgack", 32'(dbgack), 32'((in_debug || m_ack != 0) ? 1 : 0));
    // R4
    chk("R4", "irq_gated", 32'(irq_gated), 32'((irq_raw && m_mask == 0) ? 1 : 0));
    chk("R4", "fiq_gated", 32'(fiq_gated), 32'((fiq_raw && m_mask == 0) ? 1 : 0));
    // R3
    chk("R3", "undef_trap", 32'(undef_trap), 32'((user_acc && m_ublk != 0) ? 1 : 0));
    // R10
    chk("R10", "fetch_req", 32'(fetch_req),
        32'((itr_wr_ok && in_debug && m_exec != 0) ? 1 : 0));
    // R11
    chk("R11", "proto_err", 32'(proto_err), 32'((!in_debug && m_exec != 0) ? 1 : 0));
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
    compare_all();
  endtask

  task automatic quiet();
    reg_wr_en = 0; rc_wr_en = 0; reg_wdata = '0; rc_wdata = '0;
    ev_undef = 0; ev_imp_abort = 0; ev_prec_abort = 0;
    user_acc = 0; itr_wr_ok = 0; irq_raw = 0; fiq_raw = 0;
  endtask

  task automatic finish_run();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  initial begin
    #(200000 * 10);
    n_bad++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    quiet();
    rst_n = 0; in_debug = 1;
    reg_wr_en = 1; reg_wdata = 32'hFFFF_FFFF;
    repeat (2) @(posedge clk);
    @(negedge clk);
    // R1: reset state with in_debug high
    chk("R1", "rdata in reset", reg_rdata, 32'd0);
    chk("R1", "dbgack in reset", 32'(dbgack), 32'd1);
    in_debug = 0; #1;
    chk("R1", "dbgack follows debug", 32'(dbgack), 32'd0);
    quiet();
    @(negedge clk); rst_n = 1;
    tick();
    chk("R1", "rdata after reset", reg_rdata, 32'd0);

    // R2 R6 R8: write all ones; sticky and reserved stay 0
    reg_wr_en = 1; reg_wdata = 32'hFFFF_FFFF; tick();
    reg_wr_en = 0;
    chk("R2", "all-ones write", reg_rdata, 32'h0000_3C00);
    // R3 R4: trap and masked interrupts
    user_acc = 1; irq_raw = 1; fiq_raw = 1; tick();
    // R11 then R10
    itr_wr_ok = 1; in_debug = 0; tick();
    in_debug = 1; tick();
    quiet();
    // clear control bits; R4 unmasked
    reg_wr_en = 1; reg_wdata = 32'h0; tick();
    reg_wr_en = 0; irq_raw = 1; user_acc = 1; itr_wr_ok = 1; tick();
    quiet();

    // R7: events outside debug ignored
    in_debug = 0; ev_undef = 1; ev_imp_abort = 1; ev_prec_abort = 1; tick();
    chk("R7", "no set outside debug", {29'd0, reg_rdata[8:6]}, 32'd0);
    // R7: events in debug set
    in_debug = 1; tick();
    chk("R7", "set in debug", {29'd0, reg_rdata[8:6]}, 32'd7);
    quiet();
    // R8: register write of zeros and rc write without bit 2
    reg_wr_en = 1; reg_wdata = 32'h0; rc_wr_en = 1; rc_wdata = 32'hFFFF_FFFB; tick();
    quiet(); tick();
    chk("R8", "flags survive writes", {29'd0, reg_rdata[8:6]}, 32'd7);
    // R9: clear with simultaneous undef event
    rc_wr_en = 1; rc_wdata = 32'h4; ev_undef = 1; tick();
    chk("R9", "set wins over clear", {29'd0, reg_rdata[8:6]}, 32'd4);
    quiet();
    rc_wr_en = 1; rc_wdata = 32'h4; tick();
    chk("R8", "clear command", {29'd0, reg_rdata[8:6]}, 32'd0);
    quiet();

    // Random traffic
    for (int i = 0; i < 4000; i++) begin
      reg_wr_en     = ($urandom % 6) == 0;
      reg_wdata     = $urandom;
      rc_wr_en      = ($urandom % 8) == 0;
      rc_wdata      = $urandom;
      in_debug      = ($urandom % 3) != 0;
      ev_undef      = ($urandom % 7) == 0;
      ev_imp_abort  = ($urandom % 7) == 0;
      ev_prec_abort = ($urandom % 7) == 0;
      user_acc      = ($urandom % 2) == 0;
      itr_wr_ok     = ($urandom % 2) == 0;
      irq_raw       = ($urandom % 2) == 0;
      fiq_raw       = ($urandom % 2) == 0;
      tick();
    end
    finish_run();
  end
endmodule